// File: doc/BRIEF.md
# Interleaved Thread Slot Scheduler

This block decides, once per clock, which hardware thread context may send an instruction into a single shared in-order pipeline. The thread ID it emits goes down the pipe with the instruction, so that each later stage reads and writes the state of that thread.

It has three selectable policies:

- **Fixed rotation.** Each thread owns one slot in a repeating cycle of N slots.
- **Programmed slot table.** Software loads S entries, each naming a thread, and the hardware walks through them in order.
- **Rotating priority.** The block picks among the threads that are ready, starting after the last one granted.

In both rotating policies a slot whose owner is not ready becomes a pipeline bubble. The slot is never handed to another thread.

Software writes the table through a staging copy. The copy becomes live only at the boundary of a table rotation, so a rotation in progress is never torn by a write. Every output is registered: a decision made from the inputs at one clock edge appears on the outputs after that edge.

Top module: `thread_slot_sched`

## Requirements
- R1: Mode code 0 (fixed rotation): the slot owner steps 0, 1, …, N-1 and then wraps, advancing one per cycle. When the owner's ready bit is high, that thread is issued with `issue_valid_o`=1 and `issue_tid_o` equal to the owner.
- R2: Fixed rotation, owner not ready: the cycle is a bubble (`issue_valid_o`=0, `bubble_o`=1). `issue_tid_o` still shows the owner, and no other thread is issued in that slot.
- R3: Mode code 1 (table): the slot counter steps 0 … S-1 and then wraps. Slot k issues the thread stored in live entry k if that thread is ready, and is a bubble otherwise. A thread may occupy several entries.
- R4: A table write (`tbl_we_i`, address `tbl_addr_i`, thread `tbl_data_i`) lands in a staging copy. The live table is loaded from the staging copy in two cases: at the edge where the table counter moves from slot S-1 to slot 0, and at every edge while table mode is not selected. The staging value used is the one held before that edge's write.
- R5: Mode code 2 (priority): the issued thread is the first ready thread found by searching upward from the pointer, wrapping at N. After a grant to thread g, the pointer becomes g+1 modulo N.
- R6: Priority mode with no ready thread: the cycle is a bubble with `issue_tid_o`=0, and the pointer is left unchanged.
- R7: Outputs are registered and reflect the inputs at the previous clock edge. After reset, exactly one of `issue_valid_o` and `bubble_o` is high on each cycle. A thread whose ready bit was low is never issued.
- R8: While `rst` is high, all three outputs are 0. Reset also clears every table entry (live and staging) to thread 0 and sets the rotation counters and the priority pointer to 0.
- R9: Mode code 3 behaves as fixed rotation. The fixed counter restarts at slot 0 whenever fixed rotation is not selected, and so does the table counter whenever table mode is not selected. The priority pointer keeps its value across mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready_i | input | NUM_THREADS | Per-thread ready flags |
| mode_i | input | 2 | Policy: 0 fixed, 1 table, 2 priority, 3 fixed |
| tbl_we_i | input | 1 | Slot table write enable |
| tbl_addr_i | input | clog2(NUM_SLOTS) | Slot table entry to write |
| tbl_data_i | input | clog2(NUM_THREADS) | Thread ID written to the entry |
| issue_valid_o | output | 1 | An instruction from `issue_tid_o` issues this cycle |
| issue_tid_o | output | clog2(NUM_THREADS) | Selected thread ID, carried down the pipe |
| bubble_o | output | 1 | This cycle is a pipeline bubble |

## Verification
The bench drives the case where a rotation slot's owner is not ready while other threads are. A design that donated the slot would show a different thread ID or a valid issue where a bubble belongs.

It writes table entries in the middle of a rotation and checks that the old entries stay in force up to the wrap. A design applying writes at once would issue the new thread early.

In priority mode it checks:
- the wrap of the search past thread N-1;
- that the pointer holds when nothing is ready, where a design that advanced it would skip a thread afterwards;
- that the pointer survives mode changes.

After switching into each rotating mode it also checks that the counters restart at slot 0.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic [1:0] {
    SCHED_FIXED = 2'd0,
    SCHED_TABLE = 2'd1,
    SCHED_PRIO  = 2'd2,
    SCHED_ALTFX = 2'd3
  } sched_mode_e;
endpackage

// File: rtl/tss_fixed_rr.sv
module tss_fixed_rr #(
  parameter int NUM_THREADS = 8,
  localparam int TW = $clog2(NUM_THREADS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [TW-1:0] owner_o
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (cnt == TW'(NUM_THREADS - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign owner_o = cnt;
endmodule

// File: rtl/tss_slot_table.sv
module tss_slot_table #(
  parameter int NUM_THREADS = 8,
  parameter int NUM_SLOTS   = 16,
  localparam int TW = $clog2(NUM_THREADS),
  localparam int SW = $clog2(NUM_SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          we,
  input  logic [SW-1:0] waddr,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] slot_tid_o
);
  logic [TW-1:0] staging [NUM_SLOTS];
  logic [TW-1:0] live    [NUM_SLOTS];
  logic [SW-1:0] slot;
  logic          at_last;

  assign at_last = (slot == SW'(NUM_SLOTS - 1));

  // staging copy: one write port per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLOTS; i++) staging[i] <= '0;
    end else if (we && (int'(waddr) < NUM_SLOTS)) begin
      staging[waddr] <= wdata;
    end
  end

  // live copy reloads outside the mode or on a rotation wrap
  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) live[i] <= '0;
    end else if (!en) begin
      slot <= '0;
      live <= staging;
    end else if (at_last) begin
      slot <= '0;
      live <= staging;
    end else begin
      slot <= slot + 1'b1;
    end
  end

  assign slot_tid_o = live[slot];
endmodule

// File: rtl/tss_prio_arb.sv
module tss_prio_arb #(
  parameter int NUM_THREADS = 8,
  localparam int TW = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic [NUM_THREADS-1:0] req,
  output logic                   found_o,
  output logic [TW-1:0]          gid_o
);
  logic [TW-1:0] ptr;

  always_comb begin
    found_o = 1'b0;
    gid_o   = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      automatic int idx = (int'(ptr) + i) % NUM_THREADS;
      if (!found_o && req[idx]) begin
        found_o = 1'b1;
        gid_o   = TW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (en && found_o) begin
      ptr <= (gid_o == TW'(NUM_THREADS - 1)) ? '0 : gid_o + 1'b1;
    end
  end
endmodule

// File: rtl/thread_slot_sched.sv
module thread_slot_sched #(
  parameter int NUM_THREADS = 8,
  parameter int NUM_SLOTS   = 16,
  localparam int TW = $clog2(NUM_THREADS),
  localparam int SW = $clog2(NUM_SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_THREADS-1:0] ready_i,
  input  logic [1:0]             mode_i,
  input  logic                   tbl_we_i,
  input  logic [SW-1:0]          tbl_addr_i,
  input  logic [TW-1:0]          tbl_data_i,
  output logic                   issue_valid_o,
  output logic [TW-1:0]          issue_tid_o,
  output logic                   bubble_o
);
  import tss_pkg::*;

  sched_mode_e   mode;
  logic          fix_en, tbl_en, pri_en;
  logic [TW-1:0] fix_owner, tbl_owner, pri_gid;
  logic          pri_found;
  logic          sel_valid;
  logic [TW-1:0] sel_tid;

  assign mode   = sched_mode_e'(mode_i);
  assign tbl_en = (mode == SCHED_TABLE);
  assign pri_en = (mode == SCHED_PRIO);
  assign fix_en = !tbl_en && !pri_en;

  tss_fixed_rr #(.NUM_THREADS(NUM_THREADS)) u_fixed (
    .clk(clk), .rst(rst), .en(fix_en), .owner_o(fix_owner)
  );

  tss_slot_table #(.NUM_THREADS(NUM_THREADS), .NUM_SLOTS(NUM_SLOTS)) u_table (
    .clk(clk), .rst(rst), .en(tbl_en), .we(tbl_we_i),
    .waddr(tbl_addr_i), .wdata(tbl_data_i), .slot_tid_o(tbl_owner)
  );

  tss_prio_arb #(.NUM_THREADS(NUM_THREADS)) u_prio (
    .clk(clk), .rst(rst), .en(pri_en), .req(ready_i),
    .found_o(pri_found), .gid_o(pri_gid)
  );

  always_comb begin
    unique case (mode)
      SCHED_TABLE: begin
        sel_tid   = tbl_owner;
        sel_valid = ready_i[tbl_owner];
      end
      SCHED_PRIO: begin
        sel_tid   = pri_gid;
        sel_valid = pri_found;
      end
      default: begin
        sel_tid   = fix_owner;
        sel_valid = ready_i[fix_owner];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid_o <= 1'b0;
      issue_tid_o   <= '0;
      bubble_o      <= 1'b0;
    end else begin
      issue_valid_o <= sel_valid;
      issue_tid_o   <= sel_tid;
      bubble_o      <= !sel_valid;
    end
  end
endmodule

// File: rtl/tss_chk.sv
module tss_chk #(
  parameter int NUM_THREADS = 8,
  localparam int TW = $clog2(NUM_THREADS)
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_THREADS-1:0] ready_i,
  input logic [1:0]             mode_i,
  input logic                   issue_valid_o,
  input logic [TW-1:0]          issue_tid_o,
  input logic                   bubble_o
);
  logic [1:0]             cyc;
  logic [NUM_THREADS-1:0] ready_q;
  logic [1:0]             mode_q, mode_qq;
  logic [TW-1:0]          tid_q;
  logic                   q_fixed, qq_fixed;
  logic [TW-1:0]          tid_next;

  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 1'b1;
    ready_q <= ready_i;
    mode_q  <= mode_i;
    mode_qq <= mode_q;
    tid_q   <= issue_tid_o;
  end

  assign q_fixed  = (mode_q == 2'd0) || (mode_q == 2'd3);
  assign qq_fixed = (mode_qq == 2'd0) || (mode_qq == 2'd3);
  assign tid_next = (tid_q == TW'(NUM_THREADS - 1)) ? '0 : tid_q + 1'b1;

  // R7
  valid_xor_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd1) |-> (issue_valid_o != bubble_o));

  // R7
  issue_only_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd1) && issue_valid_o |-> ready_q[issue_tid_o]);

  // R2
  slot_not_donated_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd1) && (mode_q != 2'd2) |-> (issue_valid_o == ready_q[issue_tid_o]));

  // R1
  fixed_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2) && q_fixed && qq_fixed |-> (issue_tid_o == tid_next));

  // R6
  prio_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd1) && (mode_q == 2'd2) |-> (issue_valid_o == (ready_q != '0)));
endmodule

bind thread_slot_sched tss_chk #(.NUM_THREADS(NUM_THREADS)) chk_i (
  .clk(clk), .rst(rst), .ready_i(ready_i), .mode_i(mode_i),
  .issue_valid_o(issue_valid_o), .issue_tid_o(issue_tid_o), .bubble_o(bubble_o)
);

// File: tb/thread_slot_sched_tb_top.sv
module thread_slot_sched_tb_top;
  localparam int N  = 8;
  localparam int S  = 16;
  localparam int TW = $clog2(N);
  localparam int SW = $clog2(S);

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  ready;
  logic [1:0]    mode;
  logic          we;
  logic [SW-1:0] waddr;
  logic [TW-1:0] wdata;
  logic          issue_valid, bubble;
  logic [TW-1:0] issue_tid;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  int m_fcnt, m_scnt, m_ptr;
  int m_stage [S];
  int m_live  [S];

  always #10 clk = ~clk;

  thread_slot_sched #(.NUM_THREADS(N), .NUM_SLOTS(S)) dut_i (
    .clk(clk), .rst(rst), .ready_i(ready), .mode_i(mode),
    .tbl_we_i(we), .tbl_addr_i(waddr), .tbl_data_i(wdata),
    .issue_valid_o(issue_valid), .issue_tid_o(issue_tid), .bubble_o(bubble)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_fcnt = 0; m_scnt = 0; m_ptr = 0;
    for (int i = 0; i < S; i++) begin m_stage[i] = 0; m_live[i] = 0; end
  endtask

  // one clock: drive, predict, advance, compare
  task automatic cycle(input logic [N-1:0] r, input logic [1:0] md,
                       input logic w, input int wa, input int wd);
    int ev, et;
    string tag;
    ready = r; mode = md; we = w; waddr = SW'(wa); wdata = TW'(wd);
    if (md == 2'd1) begin
      et = m_live[m_scnt]; ev = r[et]; tag = "R3";
      if (m_scnt == S - 1) begin
        m_scnt = 0;
        for (int i = 0; i < S; i++) m_live[i] = m_stage[i];
      end else m_scnt++;
      m_fcnt = 0;
    end else if (md == 2'd2) begin
      ev = 0; et = 0;
      for (int i = 0; i < N; i++) begin
        int idx = (m_ptr + i) % N;
        if (ev == 0 && r[idx]) begin ev = 1; et = idx; end
      end
      if (ev != 0) begin m_ptr = (et + 1) % N; tag = "R5"; end else tag = "R6";
      m_fcnt = 0; m_scnt = 0;
      for (int i = 0; i < S; i++) m_live[i] = m_stage[i];
    end else begin
      et = m_fcnt; ev = r[et]; tag = (ev != 0) ? "R1" : "R2";
      m_fcnt = (m_fcnt + 1) % N; m_scnt = 0;
      for (int i = 0; i < S; i++) m_live[i] = m_stage[i];
    end
    if (w) m_stage[wa] = wd;
    @(posedge clk); #2;
    we = 1'b0;
    chk(tag, int'(issue_valid), ev);
    chk(tag, int'(issue_tid), et);
    chk("R7", int'(bubble), (ev != 0) ? 0 : 1);
  endtask

  initial begin
    #(20 * 150000);
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    rst = 1'b1; ready = '0; mode = 2'd0; we = 1'b0; waddr = '0; wdata = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    // R8: outputs held at zero in reset
    chk("R8", int'(issue_valid), 0);
    chk("R8", int'(issue_tid), 0);
    chk("R8", int'(bubble), 0);
    rst = 1'b0;

    // R8: cleared table issues thread 0 in every slot
    cycle('1, 2'd1, 1'b0, 0, 0);
    chk("R8", int'(issue_tid), 0);
    for (int k = 0; k < S - 1; k++) cycle('1, 2'd1, 1'b0, 0, 0);

    // R1: fixed rotation, all ready
    for (int k = 0; k < 2 * N; k++) cycle('1, 2'd0, 1'b0, 0, 0);
    // R2: only odd threads ready, even slots must bubble
    for (int k = 0; k < 2 * N; k++) cycle(8'hAA, 2'd0, 1'b0, 0, 0);
    // R9: mode 3 behaves as fixed rotation
    for (int k = 0; k < N; k++) cycle(8'h0F, 2'd3, 1'b0, 0, 0);

    // R4: load table outside table mode, repeats allowed
    for (int k = 0; k < S; k++) cycle('1, 2'd0, 1'b1, k, (k % 3) + 5);
    for (int k = 0; k < S; k++) cycle(8'hE0, 2'd1, 1'b0, 0, 0);
    // R4: write slot 9 mid rotation; old entry stays until the wrap
    for (int k = 0; k < 4; k++) cycle('1, 2'd1, 1'b0, 0, 0);
    cycle('1, 2'd1, 1'b1, 9, 2);
    for (int k = 0; k < 4; k++) cycle('1, 2'd1, 1'b0, 0, 0);
    cycle('1, 2'd1, 1'b0, 0, 0);
    chk("R4", int'(issue_tid), 5);
    for (int k = 0; k < S - 10 + 9; k++) cycle('1, 2'd1, 1'b0, 0, 0);
    cycle('1, 2'd1, 1'b0, 0, 0);
    chk("R4", int'(issue_tid), 2);

    // R5: rotating priority with wrap at N
    cycle(8'h81, 2'd2, 1'b0, 0, 0);
    cycle(8'h81, 2'd2, 1'b0, 0, 0);
    cycle(8'h81, 2'd2, 1'b0, 0, 0);
    // R6: no ready thread, pointer holds
    cycle(8'h00, 2'd2, 1'b0, 0, 0);
    cycle(8'h10, 2'd2, 1'b0, 0, 0);
    cycle('1, 2'd2, 1'b0, 0, 0);
    chk("R6", int'(issue_tid), 5);
    // R9: restart of the fixed counter, pointer survives
    cycle('1, 2'd0, 1'b0, 0, 0);
    chk("R9", int'(issue_tid), 0);
    cycle('1, 2'd2, 1'b0, 0, 0);
    chk("R9", int'(issue_tid), 6);

    // mixed random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] md;
      md = (k % 40 < 30) ? mode : 2'($urandom());
      if (k % 40 == 0) md = 2'($urandom());
      cycle(N'($urandom()), md, 1'($urandom()), int'($urandom() % S), int'($urandom() % N));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule